// File: doc/BRIEF.md
# Audio Word-Clock Gating and Word-Clock Pin Source Selector

This block sits beside the serial port of a stereo audio converter. It produces the left/right word clocks for the ADC and DAC directions when the port is the master. It also decides what drives the ADC word-clock pin and when that pin is an output. Each word clock is divided down from the master clock by a programmable half-period count. An optional internal halving stage can slow the master clock first. A word clock runs only while its direction has a live channel. A linking policy can instead keep both word clocks running while any of the four channels is enabled, so that one word clock can serve both directions.

The ADC word-clock pin can be repurposed. It can carry the raw master clock, the master clock divided by 5.5 (periods of 5 and 6 cycles in turn), or the master clock divided by 6. Any of these choices makes the pin an output, whatever the master/slave and tri-state inputs say. A small state machine tracks the pin source in use, with the states WORD, MCLK, DIV55, DIV6 and RESYNC. A change of source always passes through RESYNC for one cycle. The pin is low there and the divider counter is cleared, so the new source starts on a clean high phase and no runt pulse reaches the pin.

The configuration fields (link, pin source, pre-divide) are captured on a load strobe. They clear to zero on reset.

Top module: `lrc_clk_ctrl`

## Requirements
- R1: With link=0 in master mode, the ADC word clock runs while at least one of the ADC left or ADC right enables is high. When both are low it is held low from the next cycle.
- R2: With link=0 in master mode, the DAC word clock runs while at least one of the DAC left or DAC right enables is high. When both are low it is held low from the next cycle.
- R3: With link=1, both word clocks run while any of the four channel enables is high. Both are held low when all four are low.
- R4: A running word clock toggles every `lr_half` base ticks, so its high-to-high period is 2*`lr_half` ticks. A value of 0 acts as 1.
- R5: With pre-divide=0 there is one base tick per master-clock cycle. With pre-divide=1 there is one base tick every second cycle.
- R6: With pin source 2'b00 the ADC pin carries the ADC word clock, and `adc_pin_oe` = `master` AND NOT `tri_req`.
- R7: With pin source 2'b01 the ADC pin carries the raw master clock: high in the high phase and low in the low phase. This holds even when pre-divide=1.
- R8: With pin source 2'b10 the pin is high for 3 cycles in each period. After a restart, the rising edges are spaced 5, 6, 5, 6, ... cycles apart.
- R9: With pin source 2'b11 the pin is a square wave, high for 3 cycles and low for 3 cycles.
- R10: Any non-zero pin source makes `adc_pin_oe` high, including in slave mode and with `tri_req` high.
- R11: Suppose a load strobe at clock edge e changes the pin source. The state machine is then in RESYNC after edge e+1 and the pin is low. From edge e+2 the new source starts at the beginning of its high phase.
- R12: Reset clears link, pin source and pre-divide to 0. It also holds both word clocks low and puts the state machine in WORD.
- R13: `dac_lrc_oe` = `master` AND NOT `tri_req`. In slave mode both word clocks are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Captures the three configuration fields on this edge |
| cfg_link | input | 1 | Linked word-clock stop policy |
| cfg_pin_mode | input | 2 | ADC pin source: 00 word clock, 01 master clock, 10 ÷5.5, 11 ÷6 |
| cfg_prediv | input | 1 | Halve the master clock before word-clock division |
| lr_half | input | HALF_W | Word-clock half period in base ticks |
| master | input | 1 | Serial port is master |
| tri_req | input | 1 | Request to float the word-clock pins |
| adc_en_l | input | 1 | ADC left channel enabled |
| adc_en_r | input | 1 | ADC right channel enabled |
| dac_en_l | input | 1 | DAC left channel enabled |
| dac_en_r | input | 1 | DAC right channel enabled |
| adc_pin_o | output | 1 | Value driven on the ADC word-clock pin |
| adc_pin_oe | output | 1 | Output enable of the ADC word-clock pin |
| dac_lrc_o | output | 1 | DAC word clock |
| dac_lrc_oe | output | 1 | Output enable of the DAC word-clock pin |

## Verification
A wrong run decision in the gating logic shows within one cycle. An enabled direction keeps its word clock flat, or a disabled one keeps toggling, and the bench checks this over windows of 40 cycles. A wrong divider count or a missed counter clear changes the spacing of rising edges on the pin within the first one or two periods. A skipped RESYNC state shows as a high sample on the pin in the cycle just after a source change. A wrong output-enable decision is visible at once on the enable ports.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    typedef enum logic [1:0] {
        PM_WORD  = 2'b00,
        PM_MCLK  = 2'b01,
        PM_DIV55 = 2'b10,
        PM_DIV6  = 2'b11
    } pin_mode_e;

    typedef enum logic [2:0] {
        PS_WORD,
        PS_MCLK,
        PS_DIV55,
        PS_DIV6,
        PS_RESYNC
    } pin_st_e;

    localparam int DIV_W      = 4;
    localparam int DIV55_LAST = 10;
    localparam int DIV6_LAST  = 5;
    localparam int HIGH_LEN   = 3;
    localparam int DIV55_MID  = 5;
endpackage

// File: rtl/lrc_tick.sv
module lrc_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic prediv,
    output logic tick
);
    logic phase;

    always_ff @(posedge clk) begin
        if (!rst_n || !prediv) begin
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
        end
    end

    assign tick = ~prediv | phase;
endmodule

// File: rtl/lrc_gen.sv
module lrc_gen #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              lrc
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] last;

    assign last = (half == '0) ? '0 : half - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            lrc <= 1'b0;
        end else if (tick) begin
            if (cnt >= last) begin
                cnt <= '0;
                lrc <= ~lrc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lrc_pinsel.sv
module lrc_pinsel
    import lrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      word_lrc,
    output logic      pin_o,
    output logic      resync
);
    pin_st_e              state, state_nx, target;
    logic [DIV_W-1:0]     div_cnt;

    always_comb begin
        unique case (mode)
            PM_WORD:  target = PS_WORD;
            PM_MCLK:  target = PS_MCLK;
            PM_DIV55: target = PS_DIV55;
            PM_DIV6:  target = PS_DIV6;
            default:  target = PS_WORD;
        endcase
    end

    always_comb begin
        if (state == PS_RESYNC) begin
            state_nx = target;
        end else if (state != target) begin
            state_nx = PS_RESYNC;
        end else begin
            state_nx = state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_WORD;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else begin
            unique case (state)
                PS_DIV55: div_cnt <= (div_cnt == DIV_W'(DIV55_LAST)) ? '0 : div_cnt + 1'b1;
                PS_DIV6:  div_cnt <= (div_cnt == DIV_W'(DIV6_LAST))  ? '0 : div_cnt + 1'b1;
                default:  div_cnt <= '0;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            PS_WORD:   pin_o = word_lrc;
            PS_MCLK:   pin_o = clk;
            PS_DIV55:  pin_o = (div_cnt < DIV_W'(HIGH_LEN)) ||
                               ((div_cnt >= DIV_W'(DIV55_MID)) &&
                                (div_cnt < DIV_W'(DIV55_MID + HIGH_LEN)));
            PS_DIV6:   pin_o = (div_cnt < DIV_W'(HIGH_LEN));
            PS_RESYNC: pin_o = 1'b0;
            default:   pin_o = 1'b0;
        endcase
    end

    assign resync = (state == PS_RESYNC);
endmodule

// File: rtl/lrc_clk_ctrl.sv
module lrc_clk_ctrl
    import lrc_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_link,
    input  logic [1:0]        cfg_pin_mode,
    input  logic              cfg_prediv,
    input  logic [HALF_W-1:0] lr_half,
    input  logic              master,
    input  logic              tri_req,
    input  logic              adc_en_l,
    input  logic              adc_en_r,
    input  logic              dac_en_l,
    input  logic              dac_en_r,
    output logic              adc_pin_o,
    output logic              adc_pin_oe,
    output logic              dac_lrc_o,
    output logic              dac_lrc_oe
);
    logic      link_q;
    logic      prediv_q;
    pin_mode_e mode_q;
    logic      tick;
    logic      adc_any, dac_any;
    logic      adc_run, dac_run;
    logic      adc_lrc;
    logic      pin_resync;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q   <= 1'b0;
            prediv_q <= 1'b0;
            mode_q   <= PM_WORD;
        end else if (cfg_load) begin
            link_q   <= cfg_link;
            prediv_q <= cfg_prediv;
            mode_q   <= pin_mode_e'(cfg_pin_mode);
        end
    end

    assign adc_any = adc_en_l | adc_en_r;
    assign dac_any = dac_en_l | dac_en_r;
    assign adc_run = master & (link_q ? (adc_any | dac_any) : adc_any);
    assign dac_run = master & (link_q ? (adc_any | dac_any) : dac_any);

    lrc_tick u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .prediv (prediv_q),
        .tick   (tick)
    );

    lrc_gen #(.HALF_W(HALF_W)) u_adc_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (adc_run),
        .half  (lr_half),
        .lrc   (adc_lrc)
    );

    lrc_gen #(.HALF_W(HALF_W)) u_dac_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (dac_run),
        .half  (lr_half),
        .lrc   (dac_lrc_o)
    );

    lrc_pinsel u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .word_lrc (adc_lrc),
        .pin_o    (adc_pin_o),
        .resync   (pin_resync)
    );

    assign adc_pin_oe = (mode_q != PM_WORD) | (master & ~tri_req);
    assign dac_lrc_oe = master & ~tri_req;
endmodule

// File: rtl/lrc_clk_ctrl_chk.sv
module lrc_clk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_load,
    input logic [1:0] cfg_pin_mode,
    input logic       tri_req,
    input logic       adc_en_l,
    input logic       adc_en_r,
    input logic       dac_en_l,
    input logic       dac_en_r,
    input logic       link_q,
    input logic       adc_lrc,
    input logic       pin_resync,
    input logic       adc_pin_o,
    input logic       adc_pin_oe,
    input logic       dac_lrc_o,
    input logic       dac_lrc_oe
);
    assert_adc_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_q && !adc_en_l && !adc_en_r) |=> !adc_lrc);

    assert_dac_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_q && !dac_en_l && !dac_en_r) |=> !dac_lrc_o);

    assert_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_en_l && !adc_en_r && !dac_en_l && !dac_en_r) |=> (!adc_lrc && !dac_lrc_o));

    assert_force_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_pin_mode != 2'b00) |=> adc_pin_oe);

    assert_resync_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pin_resync |-> !adc_pin_o);

    assert_dac_float_R13: assert property (@(posedge clk) disable iff (!rst_n)
        tri_req |-> !dac_lrc_oe);
endmodule

bind lrc_clk_ctrl lrc_clk_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .cfg_pin_mode (cfg_pin_mode),
    .tri_req      (tri_req),
    .adc_en_l     (adc_en_l),
    .adc_en_r     (adc_en_r),
    .dac_en_l     (dac_en_l),
    .dac_en_r     (dac_en_r),
    .link_q       (link_q),
    .adc_lrc      (adc_lrc),
    .pin_resync   (pin_resync),
    .adc_pin_o    (adc_pin_o),
    .adc_pin_oe   (adc_pin_oe),
    .dac_lrc_o    (dac_lrc_o),
    .dac_lrc_oe   (dac_lrc_oe)
);

// File: tb/test_lrc_clk_ctrl.sv
module test_lrc_clk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_load;
    logic              cfg_link;
    logic [1:0]        cfg_pin_mode;
    logic              cfg_prediv;
    logic [HALF_W-1:0] lr_half;
    logic              master, tri_req;
    logic              adc_en_l, adc_en_r, dac_en_l, dac_en_r;
    logic              adc_pin_o, adc_pin_oe, dac_lrc_o, dac_lrc_oe;

    int total = 0;
    int bad   = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lrc_clk_ctrl #(.HALF_W(HALF_W)) i_lrc_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_link(cfg_link),
        .cfg_pin_mode(cfg_pin_mode), .cfg_prediv(cfg_prediv), .lr_half(lr_half),
        .master(master), .tri_req(tri_req),
        .adc_en_l(adc_en_l), .adc_en_r(adc_en_r), .dac_en_l(dac_en_l), .dac_en_r(dac_en_r),
        .adc_pin_o(adc_pin_o), .adc_pin_oe(adc_pin_oe),
        .dac_lrc_o(dac_lrc_o), .dac_lrc_oe(dac_lrc_oe)
    );

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic probe(input int sel);
        return (sel == 0) ? adc_pin_o : dac_lrc_o;
    endfunction

    task automatic load(input logic lk, input logic [1:0] pm, input logic pd);
        cfg_link = lk; cfg_pin_mode = pm; cfg_prediv = pd; cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
    endtask

    // monitor: measures rise-to-rise spacing and pops expectations from the scoreboard
    task automatic monitor(input int sel, input string req);
        logic prev, cur;
        int   cnt;
        prev = probe(sel);
        cnt  = 0;
        do begin
            step(); cur = probe(sel); cnt++;
            if (cur && !prev) break;
            prev = cur;
        end while (cnt < 200);
        prev = 1'b1;
        while (exp_q.size() > 0) begin
            int exp_v;
            exp_v = exp_q.pop_front();
            cnt = 0;
            do begin
                step(); cur = probe(sel); cnt++;
                if (cur && !prev) break;
                prev = cur;
            end while (cnt < 200);
            prev = cur;
            check(req, cnt, exp_v);
        end
    endtask

    task automatic flat_check(input int sel, input string req);
        int highs = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (probe(sel)) highs++;
        end
        check(req, highs, 0);
    endtask

    task automatic toggles_check(input int sel, input string req);
        int highs = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (probe(sel)) highs++;
        end
        check(req, (highs > 0 && highs < 40) ? 1 : 0, 1);
    endtask

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; cfg_link = 1'b0; cfg_pin_mode = 2'b00;
        cfg_prediv = 1'b0; lr_half = 8'd4; master = 1'b1; tri_req = 1'b0;
        adc_en_l = 1'b1; adc_en_r = 1'b1; dac_en_l = 1'b1; dac_en_r = 1'b1;
        repeat (3) step();
        // R12: word clocks low while in reset
        check("R12 adc pin in reset", adc_pin_o, 0);
        check("R12 dac lrc in reset", dac_lrc_o, 0);
        rst_n = 1'b1;
        step();
        // R12 / R6: pin source defaults to word clock, driven in master mode
        check("R6 oe master", adc_pin_oe, 1);
        check("R13 dac oe master", dac_lrc_oe, 1);

        // R4 / R5: half=4, no predivide -> period 8
        repeat (3) exp_q.push_back(8);
        monitor(0, "R4 adc period");
        repeat (2) exp_q.push_back(8);
        monitor(1, "R4 dac period");

        // R4: half=0 acts as 1
        lr_half = 8'd0;
        repeat (3) exp_q.push_back(2);
        monitor(1, "R4 half zero");
        lr_half = 8'd4;

        // R5: predivide doubles period
        load(1'b0, 2'b00, 1'b1);
        repeat (3) exp_q.push_back(16);
        monitor(0, "R5 prediv period");
        load(1'b0, 2'b00, 1'b0);

        // R1: ADC stops when both ADC channels off, DAC keeps running
        adc_en_l = 1'b0; adc_en_r = 1'b0;
        step();
        flat_check(0, "R1 adc stopped");
        toggles_check(1, "R2 dac still runs");
        adc_en_r = 1'b1;
        toggles_check(0, "R1 adc one channel runs");

        // R2: DAC stops when both DAC channels off
        dac_en_l = 1'b0; dac_en_r = 1'b0;
        step();
        flat_check(1, "R2 dac stopped");

        // R3: link keeps DAC running on ADC activity
        load(1'b1, 2'b00, 1'b0);
        toggles_check(1, "R3 linked dac runs");
        adc_en_r = 1'b0; dac_en_l = 1'b1;
        toggles_check(0, "R3 linked adc runs");
        dac_en_l = 1'b0;
        step();
        flat_check(0, "R3 all off adc");
        flat_check(1, "R3 all off dac");
        adc_en_l = 1'b1; adc_en_r = 1'b1; dac_en_l = 1'b1; dac_en_r = 1'b1;
        load(1'b0, 2'b00, 1'b0);

        // R6 / R13: tri-state and slave in word mode
        tri_req = 1'b1; #1;
        check("R6 oe tri", adc_pin_oe, 0);
        check("R13 dac oe tri", dac_lrc_oe, 0);
        tri_req = 1'b0; master = 1'b0;
        step();
        check("R6 oe slave", adc_pin_oe, 0);
        flat_check(1, "R13 slave dac low");
        flat_check(0, "R13 slave adc low");

        // R7 / R10: raw master clock, predivide set, slave + tri
        tri_req = 1'b1;
        load(1'b0, 2'b01, 1'b1);
        step(); step();
        check("R10 oe mclk slave tri", adc_pin_oe, 1);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R7 mclk high phase", adc_pin_o, 1);
            #5;
            check("R7 mclk low phase", adc_pin_o, 0);
        end

        // R9 / R11: switch to div6
        load(1'b0, 2'b11, 1'b0);
        step();
        check("R11 resync low", adc_pin_o, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R11 restart high", adc_pin_o, 1);
        end
        for (int i = 0; i < 3; i++) begin
            step();
            check("R9 div6 low", adc_pin_o, 0);
        end
        repeat (3) exp_q.push_back(6);
        monitor(0, "R9 div6 period");
        check("R10 oe div6", adc_pin_oe, 1);

        // R8 / R11: switch to div5.5, restart phase known
        load(1'b0, 2'b10, 1'b0);
        step();
        check("R11 resync low 55", adc_pin_o, 0);
        exp_q.push_back(5); exp_q.push_back(6);
        exp_q.push_back(5); exp_q.push_back(6);
        monitor(0, "R8 div55 period");
        check("R10 oe div55", adc_pin_oe, 1);

        finish_run();
    end
endmodule